// File: doc/BRIEF.md
# Timer Interrupt Flag and Mask Unit

This unit sits beside a timer counter and turns its hardware events into interrupt requests for a CPU. It has up to four events: counter overflow, compare match A, compare match B and, when the `HAS_CAPTURE` parameter is set, input capture. Each event pulse sets a sticky status flag. An enable register masks the flags. A global interrupt enable from the CPU gates all of them.

Software reaches the flag and enable registers over a byte-wide register bus with one address bit. A flag is cleared in two ways: software writes a one to its bit, or the CPU acknowledges the interrupt that the flag raised. When one or more enabled flags are pending, the unit picks one by fixed priority. It latches that choice as a request plus a 2-bit vector code and holds both until the acknowledge arrives.

Top module: `tmr_irq_unit`

## Requirements
- R1: After reset all flags and enables are zero, `irq_req` is low and `irq_vec` is 0.
- R2: An event pulse sets its flag one cycle later. The flag positions are bit 0 overflow, bit 1 compare A, bit 2 compare B and bit 3 capture. The flag register is at `bus_addr`=0 and the enable register at `bus_addr`=1, with the same bit positions. Bits above the flags read as zero, and writes to them are dropped.
- R3: A bus write to the flag register clears every flag whose data bit is one and leaves flags whose data bit is zero unchanged.
- R4: An event in the same cycle as a software clear or an acknowledge clear of its flag leaves the flag set.
- R5: A request is raised only when some flag is set, its enable bit is set and `gie` is high. It is raised one cycle after that condition holds.
- R6: When several enabled flags are pending, the vector chosen is overflow (code 0), then compare A (1), then compare B (2), then capture (3).
- R7: Once raised, `irq_req` stays high with `irq_vec` unchanged until `irq_ack` is seen. This holds even if the flag is cleared by software or a higher-priority flag arrives in the meantime.
- R8: `irq_ack` while `irq_req` is high clears the flag named by `irq_vec` and drops `irq_req` for at least one cycle. The next pending source is then arbitrated afresh.
- R9: `irq_ack` while `irq_req` is low has no effect on the flags or the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ovf | input | 1 | Counter overflow event pulse |
| ev_cmpa | input | 1 | Compare match A event pulse |
| ev_cmpb | input | 1 | Compare match B event pulse |
| ev_cap | input | 1 | Input capture event pulse (used when HAS_CAPTURE=1) |
| bus_sel | input | 1 | Register bus select |
| bus_wr | input | 1 | Register bus write strobe |
| bus_addr | input | 1 | 0 = flag register, 1 = enable register |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data of the addressed register |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Acknowledge of the presented request |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | 2 | Vector code of the request |

## Verification
Two collisions get the most attention. In the first, a hardware event arrives in the same cycle as the clear of its own flag, whether the clear comes from a software write of one or from an acknowledge. The bench drives the event pulse and the clear together, then reads the flag register back and expects the bit still set. In the second, a higher-priority flag or a software clear lands while a request is already held. Here the bench expects the request and its vector to stay unchanged until the acknowledge. A behavioural model steps alongside the design and compares request, vector and read data every cycle.

// File: rtl/tmr_irq_unit.sv
`timescale 1ns/1ps
module tmr_irq_unit #(
  parameter bit HAS_CAPTURE = 1'b1,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_ovf,
  input  logic          ev_cmpa,
  input  logic          ev_cmpb,
  input  logic          ev_cap,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic          bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          gie,
  input  logic          irq_ack,
  output logic          irq_req,
  output logic [1:0]    irq_vec
);
  localparam int NF = HAS_CAPTURE ? 4 : 3;

  logic [NF-1:0] flags_q, mask_q, ev, pend, clr_sw, clr_ack;
  logic [1:0]    pick;
  logic          wr_flag, wr_mask, take;

  generate
    if (HAS_CAPTURE) begin : g_cap
      assign ev = {ev_cap, ev_cmpb, ev_cmpa, ev_ovf};
    end else begin : g_nocap
      assign ev = {ev_cmpb, ev_cmpa, ev_ovf};
    end
  endgenerate

  assign wr_flag = bus_sel & bus_wr & ~bus_addr;
  assign wr_mask = bus_sel & bus_wr &  bus_addr;
  assign pend    = gie ? (flags_q & mask_q) : '0;
  assign take    = irq_req & irq_ack;
  assign clr_sw  = wr_flag ? bus_wdata[NF-1:0] : '0;

  always_comb begin
    pick = '0;
    for (int i = NF - 1; i >= 0; i--)
      if (pend[i]) pick = 2'(i);
  end

  always_comb begin
    clr_ack = '0;
    for (int i = 0; i < NF; i++)
      clr_ack[i] = take && (irq_vec == 2'(i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      mask_q  <= '0;
      irq_req <= 1'b0;
      irq_vec <= '0;
    end else begin
      flags_q <= (flags_q & ~(clr_sw | clr_ack)) | ev;
      if (wr_mask) mask_q <= bus_wdata[NF-1:0];
      if (irq_req) begin
        if (irq_ack) irq_req <= 1'b0;
      end else if (|pend) begin
        irq_req <= 1'b1;
        irq_vec <= pick;
      end
    end
  end

  assign bus_rdata = {{(DW-NF){1'b0}}, bus_addr ? mask_q : flags_q};
endmodule

module tmr_irq_unit_chk #(parameter int NF = 4) (
  input logic          clk,
  input logic          rst_n,
  input logic          gie,
  input logic [NF-1:0] ev,
  input logic [NF-1:0] flags,
  input logic [NF-1:0] mask,
  input logic          irq_ack,
  input logic          irq_req,
  input logic [1:0]    irq_vec
);
  a_r7_hold_vec: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && !irq_ack |=> irq_req && $stable(irq_vec));

  a_r8_ack_drops: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req && irq_ack |=> !irq_req);

  a_r5_gated: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && !(gie && |(flags & mask)) |=> !irq_req);

  a_r6_ovf_first: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && gie && flags[0] && mask[0] |=> irq_req && irq_vec == 2'd0);

  a_r9_idle_ack: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req && irq_ack && !gie |=> !irq_req);

  generate
    for (genvar i = 0; i < NF; i++) begin : g_bit
      a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        ev[i] |=> flags[i]);
      a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req && irq_ack && irq_vec == 2'(i) && !ev[i] |=> !flags[i]);
    end
  endgenerate
endmodule

bind tmr_irq_unit tmr_irq_unit_chk #(.NF(NF)) u_chk (
  .clk(clk), .rst_n(rst_n), .gie(gie), .ev(ev), .flags(flags_q),
  .mask(mask_q), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
);

// File: tb/tmr_irq_unit_tb_top.sv
`timescale 1ns/1ps
module tmr_irq_unit_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ev_ovf = 0, ev_cmpa = 0, ev_cmpb = 0, ev_cap = 0;
  logic bus_sel = 0, bus_wr = 0, bus_addr = 0;
  logic [7:0] bus_wdata = '0, bus_rdata;
  logic gie = 0, irq_ack = 0, irq_req;
  logic [1:0] irq_vec;

  int vectors = 0, fails = 0;
  string tag = "R1";
  int flg[4], msk[4];
  int mreq = 0, mvec = 0;

  always #2 clk = ~clk;

  tmr_irq_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ev_ovf(ev_ovf), .ev_cmpa(ev_cmpa),
    .ev_cmpb(ev_cmpb), .ev_cap(ev_cap), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .gie(gie), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
  );

  function automatic int model_rd(input logic a);
    int v = 0;
    for (int i = 0; i < 4; i++) v += (a ? msk[i] : flg[i]) << i;
    return v;
  endfunction

  task automatic model_update();
    int e[4], of[4], om[4];
    e = '{int'(ev_ovf), int'(ev_cmpa), int'(ev_cmpb), int'(ev_cap)};
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin flg[i] = 0; msk[i] = 0; end
      mreq = 0; mvec = 0;
      return;
    end
    of = flg; om = msk;
    for (int i = 0; i < 4; i++) begin
      int cleared = 0;
      if (bus_sel && bus_wr && !bus_addr && bus_wdata[i]) cleared = 1;
      if (mreq == 1 && irq_ack && mvec == i) cleared = 1;
      flg[i] = (e[i] != 0 || (of[i] != 0 && cleared == 0)) ? 1 : 0;
      if (bus_sel && bus_wr && bus_addr) msk[i] = int'(bus_wdata[i]);
    end
    if (mreq == 1) begin
      if (irq_ack) mreq = 0;
    end else if (gie) begin
      for (int i = 3; i >= 0; i--)
        if (of[i] != 0 && om[i] != 0) begin mreq = 1; mvec = i; end
    end
  endtask

  task automatic chk(input string what, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    model_update();
    #1;
    chk("irq_req", int'(irq_req), mreq);
    if (mreq == 1) chk("irq_vec", int'(irq_vec), mvec);
    chk("bus_rdata", int'(bus_rdata), model_rd(bus_addr));
  endtask

  task automatic pulse(input logic [3:0] e);
    {ev_cap, ev_cmpb, ev_cmpa, ev_ovf} = e;
    step();
    {ev_cap, ev_cmpb, ev_cmpa, ev_ovf} = '0;
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    step();
    bus_sel = 0; bus_wr = 0; bus_wdata = '0;
  endtask

  task automatic rd(input logic a, input int exp);
    bus_addr = a; #1;
    chk("register read", int'(bus_rdata), exp);
  endtask

  task automatic ack();
    irq_ack = 1; step(); irq_ack = 0;
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    tag = "R1";
    step(); step();
    rst_n = 1;
    step();
    rd(0, 0); rd(1, 0);
    chk("reset irq_req", int'(irq_req), 0);
    chk("reset irq_vec", int'(irq_vec), 0);

    tag = "R2";
    pulse(4'b0001); rd(0, 1);
    pulse(4'b0010); rd(0, 3);
    pulse(4'b0100); rd(0, 7);
    pulse(4'b1000); rd(0, 15);
    wr(1, 8'hFF); rd(1, 15);
    wr(1, 8'h00); rd(1, 0);

    tag = "R3";
    wr(0, 8'h05); rd(0, 10);
    wr(0, 8'h00); rd(0, 10);
    wr(0, 8'hFF); rd(0, 0);

    tag = "R4";
    ev_cmpa = 1; wr(0, 8'h02); ev_cmpa = 0; rd(0, 2);
    wr(0, 8'h02); rd(0, 0);

    tag = "R5";
    pulse(4'b0100); wr(1, 8'h0B);
    gie = 1; step(); step();
    chk("masked flag no req", int'(irq_req), 0);
    gie = 0; wr(1, 8'h0F); step();
    chk("gie low no req", int'(irq_req), 0);
    gie = 1; step();
    chk("enabled req", int'(irq_req), 1);
    chk("enabled vec", int'(irq_vec), 2);
    tag = "R8"; ack(); rd(0, 0);

    tag = "R6";
    gie = 0; pulse(4'b1111); gie = 1; step();
    chk("first vec", int'(irq_vec), 0);
    tag = "R7"; step(); step();
    chk("held vec", int'(irq_vec), 0);
    tag = "R8"; ack(); rd(0, 14);
    chk("drop after ack", int'(irq_req), 0);
    step();
    tag = "R6"; chk("second vec", int'(irq_vec), 1);

    tag = "R7";
    pulse(4'b0001); chk("vec kept on higher arrival", int'(irq_vec), 1);
    wr(0, 8'h02); chk("req kept on sw clear", int'(irq_req), 1);
    tag = "R8"; ack(); step();
    tag = "R6"; chk("ovf next", int'(irq_vec), 0);

    tag = "R4";
    ev_ovf = 1; ack(); ev_ovf = 0; rd(0, 13);
    step(); tag = "R8"; ack(); step(); ack(); step(); ack(); rd(0, 0);

    tag = "R9";
    gie = 0; pulse(4'b0110);
    ack(); ack(); rd(0, 6);
    chk("idle ack no req", int'(irq_req), 0);
    gie = 1; step(); step(); ack(); step(); ack(); step(); step();
    rd(0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule